// File: doc/BRIEF.md
# Output Buffer Full and Interrupt Arbiter for Two Input Sources

This block sits between two byte sources, a keyboard channel and an auxiliary (pointing device) channel, and the host side of a legacy input controller. Each source raises a level while it holds a byte for the host. The block merges the two levels with the controller's configuration byte. It produces the buffer-full flags for the status register, the same flags for the output-port image, and one level interrupt per source. It also drives a select line that tells the data-port read path which source to dequeue from.

The keyboard channel always wins. The auxiliary channel is reported, interrupts and is selected for reads only when it is the sole source with data. All outputs are registered once, so every output follows its inputs one clock later. The interrupt levels are meant for the keyboard and auxiliary lines of a legacy interrupt controller (lines 1 and 12).

Top module: `obuf_irq_arbiter`

## Requirements
- R1: Every output is registered. It reflects the inputs sampled at the previous rising clock edge, so a change on the inputs appears one cycle later.
- R2: `sts_obf_o` is 1 exactly when at least one of `kbd_pend_i` and `aux_pend_i` is 1.
- R3: `sts_aux_obf_o` is 1 exactly when `aux_pend_i` is 1 and `kbd_pend_i` is 0. With both pending it is 0, because keyboard data wins.
- R4: `aux_irq_o` is 1 exactly when auxiliary data alone is pending and configuration bit 1 (auxiliary interrupt enable) is 1.
- R5: `kbd_irq_o` is 1 exactly when `kbd_pend_i` is 1, configuration bit 0 (keyboard interrupt enable) is 1 and configuration bit 4 (keyboard disable) is 0.
- R6: `port_obf_o` equals `sts_obf_o` and `port_aux_obf_o` equals `sts_aux_obf_o` in every cycle.
- R7: `rd_sel_aux_o` is 1 (dequeue from auxiliary) only when auxiliary data alone is pending. Otherwise it is 0 (dequeue from keyboard).
- R8: Configuration bits 2, 3, 5, 6 and 7 have no effect on any output.
- R9: While `rst` is high at a rising edge, every output goes to 0 in the following cycle. The two interrupt levels are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_pend_i | input | 1 | Keyboard source holds a byte |
| aux_pend_i | input | 1 | Auxiliary source holds a byte |
| mode_i | input | MODE_W (8) | Controller configuration byte |
| sts_obf_o | output | 1 | Status: output buffer full |
| sts_aux_obf_o | output | 1 | Status: buffer holds auxiliary data |
| port_obf_o | output | 1 | Output-port image of buffer full |
| port_aux_obf_o | output | 1 | Output-port image of auxiliary full |
| kbd_irq_o | output | 1 | Keyboard interrupt level |
| aux_irq_o | output | 1 | Auxiliary interrupt level |
| rd_sel_aux_o | output | 1 | Data read dequeues from auxiliary source |

## Verification
Two things can fall in the same cycle. One is both sources raising pending together, where the keyboard must win for the flags, the select and the interrupts at once. The other is the keyboard becoming pending while keyboard-disable is set, where the gate must hold the interrupt low although the buffer-full flag rises. The bench forces both cases directly, with every combination of the interrupt-enable and disable bits. It also reaches them often in random traffic. Each cycle, every output is compared against a reference model that is written from the requirements and applied to the inputs of the previous cycle.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;

  localparam int PEND_W   = 2;
  localparam int KBD_IDX  = 0;
  localparam int AUX_IDX  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_KBD  = 2'd1,
    SEL_AUX  = 2'd2
  } src_sel_e;

  typedef struct packed {
    logic obf;
    logic aux_obf;
    logic kbd_irq;
    logic aux_irq;
    logic rd_aux;
  } arb_out_t;

endpackage

// File: rtl/obuf_pend_decode.sv
module obuf_pend_decode
  import obuf_arb_pkg::*;
(
  input  logic [PEND_W-1:0] pend_i,
  output src_sel_e          sel_o
);

  always_comb begin
    if (pend_i[KBD_IDX])      sel_o = SEL_KBD;
    else if (pend_i[AUX_IDX]) sel_o = SEL_AUX;
    else                      sel_o = SEL_NONE;
  end

endmodule

// File: rtl/obuf_irq_gate.sv
module obuf_irq_gate
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W      = 8,
  parameter int KBD_IEN_BIT = 0,
  parameter int AUX_IEN_BIT = 1,
  parameter int KBD_DIS_BIT = 4
) (
  input  src_sel_e          sel_i,
  input  logic [MODE_W-1:0] mode_i,
  output arb_out_t          nxt_o
);

  logic kbd_ok;
  logic aux_ok;
  logic unused_mode;

  assign kbd_ok      = mode_i[KBD_IEN_BIT] & ~mode_i[KBD_DIS_BIT];
  assign aux_ok      = mode_i[AUX_IEN_BIT];
  assign unused_mode = ^mode_i;

  always_comb begin
    nxt_o = '0;
    unique case (sel_i)
      SEL_KBD: begin
        nxt_o.obf     = 1'b1;
        nxt_o.kbd_irq = kbd_ok;
      end
      SEL_AUX: begin
        nxt_o.obf     = 1'b1;
        nxt_o.aux_obf = 1'b1;
        nxt_o.aux_irq = aux_ok;
        nxt_o.rd_aux  = 1'b1;
      end
      default: nxt_o = '0;
    endcase
  end

endmodule

// File: rtl/obuf_out_reg.sv
module obuf_out_reg
  import obuf_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  arb_out_t nxt_i,
  output arb_out_t q_o,
  output logic     port_obf_o,
  output logic     port_aux_obf_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o            <= '0;
      port_obf_o     <= 1'b0;
      port_aux_obf_o <= 1'b0;
    end else begin
      q_o            <= nxt_i;
      port_obf_o     <= nxt_i.obf;
      port_aux_obf_o <= nxt_i.aux_obf;
    end
  end

endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W      = 8,
  parameter int KBD_IEN_BIT = 0,
  parameter int AUX_IEN_BIT = 1,
  parameter int KBD_DIS_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_pend_i,
  input  logic              aux_pend_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              sts_obf_o,
  output logic              sts_aux_obf_o,
  output logic              port_obf_o,
  output logic              port_aux_obf_o,
  output logic              kbd_irq_o,
  output logic              aux_irq_o,
  output logic              rd_sel_aux_o
);

  logic [PEND_W-1:0] pend;
  src_sel_e          sel;
  arb_out_t          nxt;
  arb_out_t          q;

  assign pend[KBD_IDX] = kbd_pend_i;
  assign pend[AUX_IDX] = aux_pend_i;

  obuf_pend_decode u_dec (
    .pend_i (pend),
    .sel_o  (sel)
  );

  obuf_irq_gate #(
    .MODE_W      (MODE_W),
    .KBD_IEN_BIT (KBD_IEN_BIT),
    .AUX_IEN_BIT (AUX_IEN_BIT),
    .KBD_DIS_BIT (KBD_DIS_BIT)
  ) u_gate (
    .sel_i  (sel),
    .mode_i (mode_i),
    .nxt_o  (nxt)
  );

  obuf_out_reg u_reg (
    .clk            (clk),
    .rst            (rst),
    .nxt_i          (nxt),
    .q_o            (q),
    .port_obf_o     (port_obf_o),
    .port_aux_obf_o (port_aux_obf_o)
  );

  assign sts_obf_o     = q.obf;
  assign sts_aux_obf_o = q.aux_obf;
  assign kbd_irq_o     = q.kbd_irq;
  assign aux_irq_o     = q.aux_irq;
  assign rd_sel_aux_o  = q.rd_aux;

  // R1
  pend_to_obf_chk: assert property (@(posedge clk) disable iff (rst)
    (kbd_pend_i || aux_pend_i) |=> sts_obf_o);

  // R3
  kbd_wins_chk: assert property (@(posedge clk) disable iff (rst)
    kbd_pend_i |=> (!sts_aux_obf_o && !rd_sel_aux_o && !aux_irq_o));

  // R4
  aux_irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    aux_irq_o |-> (sts_aux_obf_o && sts_obf_o));

  // R5
  kbd_irq_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (kbd_pend_i && mode_i[KBD_DIS_BIT]) |=> !kbd_irq_o);

  // R7
  rd_sel_alone_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sel_aux_o |-> (sts_obf_o && !kbd_irq_o));

  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(kbd_irq_o && aux_irq_o));

endmodule

// File: tb/obuf_irq_arbiter_test.sv
module obuf_irq_arbiter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kp  = 1'b0;
  logic       ap  = 1'b0;
  logic [7:0] md  = 8'h00;
  logic sts_obf, sts_aux, p_obf, p_aux, kirq, airq, rsel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  obuf_irq_arbiter uut (
    .clk(clk), .rst(rst), .kbd_pend_i(kp), .aux_pend_i(ap), .mode_i(md),
    .sts_obf_o(sts_obf), .sts_aux_obf_o(sts_aux), .port_obf_o(p_obf),
    .port_aux_obf_o(p_aux), .kbd_irq_o(kirq), .aux_irq_o(airq),
    .rd_sel_aux_o(rsel)
  );

  function automatic logic [6:0] model(logic k, logic a, logic [7:0] m);
    logic obf, aobf, ki, ai, rs;
    obf  = k | a;
    aobf = a & ~k;
    ki   = k & m[0] & ~m[4];
    ai   = aobf & m[1];
    rs   = aobf;
    return {obf, aobf, obf, aobf, ki, ai, rs};
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (kp=%b ap=%b mode=%h)", req, act, exp, kp, ap, md);
    end
  endtask

  task automatic step_check(logic k, logic a, logic [7:0] m);
    logic [6:0] e;
    @(negedge clk);
    kp = k; ap = a; md = m;
    e = model(k, a, m);
    @(negedge clk);
    chk("R2", sts_obf, e[6]);
    chk("R3", sts_aux, e[5]);
    chk("R6", p_obf,   e[4]);
    chk("R6", p_aux,   e[3]);
    chk("R5", kirq,    e[2]);
    chk("R4", airq,    e[1]);
    chk("R7", rsel,    e[0]);
    chk("R9", kirq & airq, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] m0;
    logic [6:0] ref_a;
    logic [6:0] ref_b;
    void'($urandom(32'd20240611));
    kp = 1'b1; ap = 1'b1; md = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", sts_obf | sts_aux | p_obf | p_aux | kirq | airq | rsel, 1'b0);
    rst = 1'b0;
    kp = 1'b0; ap = 1'b0; md = 8'h03;
    @(negedge clk);
    // R1: output one cycle after input change
    kp = 1'b1;
    @(posedge clk); #1;
    chk("R1", sts_obf, 1'b1);
    @(negedge clk); kp = 1'b0;
    #1;
    chk("R1", sts_obf, 1'b1);
    @(posedge clk); #1;
    chk("R1", sts_obf, 1'b0);
    // directed: both pending with every enable/disable combination
    for (int i = 0; i < 8; i++) begin
      m0 = {3'b000, i[2], 2'b00, i[1], i[0]};
      step_check(1'b1, 1'b1, m0);
      step_check(1'b1, 1'b0, m0);
      step_check(1'b0, 1'b1, m0);
      step_check(1'b0, 1'b0, m0);
    end
    // R8: unused mode bits do not change outputs
    for (int i = 0; i < 16; i++) begin
      m0 = 8'($urandom);
      step_check(i[0], i[1], m0);
      ref_a = {sts_obf, sts_aux, p_obf, p_aux, kirq, airq, rsel};
      step_check(i[0], i[1], m0 ^ 8'hEC);
      ref_b = {sts_obf, sts_aux, p_obf, p_aux, kirq, airq, rsel};
      chk("R8", ref_a == ref_b, 1'b1);
    end
    // random traffic
    for (int i = 0; i < 600; i++)
      step_check(1'($urandom), 1'($urandom), 8'($urandom));
    // R9: reset in mid-run clears outputs
    @(negedge clk); kp = 1'b1; ap = 1'b0; md = 8'h01; rst = 1'b1;
    @(negedge clk);
    chk("R9", sts_obf | kirq | p_obf, 1'b0);
    rst = 1'b0;
    step_check(1'b0, 1'b1, 8'h02);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule